// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block turns a fan's tachometer pulse train into a 16-bit period reading. The reading is the number of reference clock cycles between two consecutive rising edges of the tachometer signal, so a larger number means a slower fan. The raw tachometer input is asynchronous. It goes through a synchronizer and a rising-edge detector before it reaches the counter. A measurement runs only while the PWM-active qualifier is high. Dropping the qualifier stops the counter and discards a half-finished measurement. The reading that was last completed is kept.

When the counter reaches all ones, it stops counting and the all-ones value is loaded as the reading. This marks a fan that has stalled or has stopped giving edges. Software reads the result as two bytes. Reading the low byte freezes the value shown on both byte ports until the high byte has been read, so the two halves always belong to the same measurement.

A programmable limit is applied as an upper bound on the period. A sticky slow-fan flag is raised whenever the reading exceeds the limit while PWM is active.

Top module: `fan_period_meter`

## Requirements
- R1: After reset, both byte ports read 0x00 and the slow-fan flag is 0.
- R2: With PWM active, once two synchronized tachometer rising edges have been seen, the 16-bit reading equals the number of clock cycles between them. The low byte carries bits 7:0 and the high byte carries bits 15:8.
- R3: Each completed measurement replaces the previous reading, across different fan speeds.
- R4: A low-byte read strobe latches the whole reading. Until the next high-byte read strobe, the high-byte port keeps the latched value, even if a new measurement completes in the meantime.
- R5: If no rising edge arrives before the counter reaches 0xFFFF, the counter holds at 0xFFFF and the reading becomes 0xFFFF.
- R6: While PWM is active and the reading is strictly greater than the limit, the slow-fan flag is set. It stays set until a status read strobe arrives while that condition is absent. A status read while the condition is present leaves the flag set.
- R7: While PWM is inactive, the slow-fan flag is not set and the counter does not run, so no stall reading can build up.
- R8: Until the first measurement completes, the reading stays 0x0000. A single rising edge is not enough to complete a measurement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fixed-rate reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tachIn | input | 1 | Raw asynchronous tachometer signal |
| pwmActive | input | 1 | High while the fan's PWM drive is on |
| limitVal | input | 16 | Upper bound on the period before the fan counts as slow |
| rdLoStb | input | 1 | Low-byte read strobe; latches the full reading |
| rdHiStb | input | 1 | High-byte read strobe; releases the latch |
| rdStatusStb | input | 1 | Status read strobe; may clear the slow-fan flag |
| loByte | output | 8 | Reading bits 7:0 |
| hiByte | output | 8 | Reading bits 15:8 |
| slowFlag | output | 1 | Sticky slow-or-stalled flag |

## Verification
Two situations are hard to reach from the ports. The first is the stall path: it only shows after 65535 idle cycles with PWM on. The stimulus therefore produces a short valid period first and then holds the tachometer input quiet for longer than the full counter range. The second is the latch crossing a measurement: the low byte is read, PWM is toggled to restart the measurement, and a period with a different high byte completes before the high byte is read. This shows that the high byte still reports the older value.

// File: rtl/fan_tach_pkg.sv
package fan_tach_pkg;
  // Strobes from the edge controller to the counting datapath
  typedef struct packed {
    logic restart;  // PWM inactive: clear counter, drop measurement
    logic start;    // first rising edge: begin a period
    logic capture;  // later rising edge: store period, begin next
  } tachStrobe_t;
endpackage

// File: rtl/tach_edge_ctrl.sv
module tach_edge_ctrl
  import fan_tach_pkg::*;
#(
  parameter int SyncStages = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tachIn,
  input  logic        pwmActive,
  output tachStrobe_t strobe
);
  localparam int TopBit = SyncStages - 1;

  logic [TopBit:0] syncQ;
  logic            tachPrev;
  logic            armed;
  logic            rise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      tachPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[TopBit-1:0], tachIn};
      tachPrev <= syncQ[TopBit];
    end
  end

  assign rise = syncQ[TopBit] & ~tachPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (!pwmActive) armed <= 1'b0;
    else if (rise)       armed <= 1'b1;
  end

  always_comb begin
    strobe.restart = ~pwmActive;
    strobe.start   = pwmActive & rise & ~armed;
    strobe.capture = pwmActive & rise & armed;
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rise |=> !rise); // R2
  AST_START_THEN_ARMED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.start && pwmActive) |=> (!strobe.start)); // R8
endmodule

// File: rtl/tach_period_dp.sv
module tach_period_dp
  import fan_tach_pkg::*;
#(
  parameter int CntW = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  tachStrobe_t     strobe,
  input  logic            pwmActive,
  input  logic [CntW-1:0] limitVal,
  input  logic            rdLoStb,
  input  logic            rdHiStb,
  input  logic            rdStatusStb,
  output logic [7:0]      loByte,
  output logic [CntW-9:0] hiByte,
  output logic            slowFlag
);
  localparam logic [CntW-1:0] CntMax = '1;
  localparam logic [CntW-1:0] CntOne = CntW'(1);

  logic [CntW-1:0] cnt;
  logic [CntW-1:0] result;
  logic [CntW-1:0] snap;
  logic [CntW-1:0] view;
  logic            frozen;
  logic            overLimit;

  // Period counter, saturating at all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                cnt <= '0;
    else if (strobe.restart)                  cnt <= '0;
    else if (strobe.start || strobe.capture)  cnt <= CntOne;
    else if (cnt != CntMax)                   cnt <= cnt + CntOne;
  end

  // Reading register: period on capture, all ones on saturation
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   result <= '0;
    else if (strobe.capture)                     result <= cnt;
    else if (!strobe.restart && cnt == CntMax)   result <= CntMax;
  end

  // Two-byte coherent read latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frozen <= 1'b0;
      snap   <= '0;
    end else if (rdLoStb) begin
      frozen <= 1'b1;
      snap   <= result;
    end else if (rdHiStb) begin
      frozen <= 1'b0;
    end
  end

  assign view   = frozen ? snap : result;
  assign loByte = view[7:0];
  assign hiByte = view[CntW-1:8];

  // Sticky slow-fan flag
  assign overLimit = pwmActive && (result > limitVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            slowFlag <= 1'b0;
    else if (overLimit)   slowFlag <= 1'b1;
    else if (rdStatusStb) slowFlag <= 1'b0;
  end

  AST_SAT_LOADS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CntMax && !strobe.restart) |=> (result == CntMax)); // R5
  AST_NO_FLAG_PWM_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!pwmActive && !slowFlag) |=> !slowFlag); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (slowFlag && !rdStatusStb) |=> slowFlag); // R6
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && !rdHiStb && !rdLoStb) |=> $stable(hiByte)); // R4
  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.restart |=> (cnt == '0)); // R7
endmodule

// File: rtl/fan_period_meter.sv
module fan_period_meter
  import fan_tach_pkg::*;
#(
  parameter int CntW       = 16,
  parameter int SyncStages = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            tachIn,
  input  logic            pwmActive,
  input  logic [CntW-1:0] limitVal,
  input  logic            rdLoStb,
  input  logic            rdHiStb,
  input  logic            rdStatusStb,
  output logic [7:0]      loByte,
  output logic [CntW-9:0] hiByte,
  output logic            slowFlag
);
  tachStrobe_t strobe;

  tach_edge_ctrl #(.SyncStages(SyncStages)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .tachIn    (tachIn),
    .pwmActive (pwmActive),
    .strobe    (strobe)
  );

  tach_period_dp #(.CntW(CntW)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pwmActive   (pwmActive),
    .limitVal    (limitVal),
    .rdLoStb     (rdLoStb),
    .rdHiStb     (rdHiStb),
    .rdStatusStb (rdStatusStb),
    .loByte      (loByte),
    .hiByte      (hiByte),
    .slowFlag    (slowFlag)
  );
endmodule

// File: tb/sim_fan_period_meter.sv
module sim_fan_period_meter;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tachIn = 1'b0;
  logic        pwmActive = 1'b0;
  logic [15:0] limitVal = 16'hFFFF;
  logic        rdLoStb = 1'b0;
  logic        rdHiStb = 1'b0;
  logic        rdStatusStb = 1'b0;
  logic [7:0]  loByte;
  logic [7:0]  hiByte;
  logic        slowFlag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string req;
    int    expv;
  } expItem_t;

  expItem_t expQ[$];
  int       actQ[$];

  always #(ClkPeriod/2) clk = ~clk;

  fan_period_meter u0 (
    .clk(clk), .rstN(rstN), .tachIn(tachIn), .pwmActive(pwmActive),
    .limitVal(limitVal), .rdLoStb(rdLoStb), .rdHiStb(rdHiStb),
    .rdStatusStb(rdStatusStb), .loByte(loByte), .hiByte(hiByte),
    .slowFlag(slowFlag)
  );

  // Driver side: expectation and observation go into the scoreboard
  task automatic expectVal(input string req, input int v);
    expItem_t it;
    it.req  = req;
    it.expv = v;
    expQ.push_back(it);
  endtask

  task automatic observe(input int v);
    actQ.push_back(v);
  endtask

  // Monitor: pops and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (actQ.size() > 0 && expQ.size() > 0) begin
        automatic expItem_t it = expQ.pop_front();
        automatic int a = actQ.pop_front();
        checks++;
        if (a !== it.expv) begin
          errors++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.req, a, it.expv);
        end
      end
    end
  end

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One tach period: high for two cycles, low for the rest
  task automatic pulses(input int period, input int count);
    for (int k = 0; k < count; k++) begin
      @(negedge clk); tachIn = 1'b1;
      waitCycles(2);
      tachIn = 1'b0;
      waitCycles(period - 3);
    end
  endtask

  task automatic restartMeas();
    @(negedge clk); pwmActive = 1'b0;
    @(negedge clk); pwmActive = 1'b1;
  endtask

  task automatic readWord(input string req, input int expv);
    int lo;
    int hi;
    expectVal(req, expv);
    @(negedge clk); rdLoStb = 1'b1; lo = loByte;
    @(negedge clk); rdLoStb = 1'b0; rdHiStb = 1'b1; hi = hiByte;
    @(negedge clk); rdHiStb = 1'b0;
    observe((hi << 8) | lo);
  endtask

  task automatic checkFlag(input string req, input int expv);
    expectVal(req, expv);
    @(negedge clk); observe(int'(slowFlag));
  endtask

  task automatic statusRead();
    @(negedge clk); rdStatusStb = 1'b1;
    @(negedge clk); rdStatusStb = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    expectVal("R1 lo", 0);   @(negedge clk); observe(int'(loByte));
    expectVal("R1 hi", 0);   @(negedge clk); observe(int'(hiByte));
    checkFlag("R1 flag", 0);

    // R8: one edge does not complete a measurement
    pwmActive = 1'b1;
    pulses(100, 1);
    waitCycles(20);
    readWord("R8 single edge", 0);

    // R2: basic period
    restartMeas();
    pulses(300, 2);
    readWord("R2 period 300", 300);

    // R3: new speeds replace the reading
    restartMeas();
    pulses(1000, 2);
    readWord("R3 period 1000", 1000);
    restartMeas();
    pulses(40, 2);
    readWord("R3 period 40", 40);

    // R4: latch across a new measurement
    restartMeas();
    pulses(564, 2);
    expectVal("R4 lo latched", 'h34);
    @(negedge clk); rdLoStb = 1'b1; observe(int'(loByte));
    @(negedge clk); rdLoStb = 1'b0;
    restartMeas();
    pulses(768, 2);
    expectVal("R4 hi frozen", 'h02);
    @(negedge clk); rdHiStb = 1'b1; observe(int'(hiByte));
    @(negedge clk); rdHiStb = 1'b0;
    readWord("R4 after release", 768);

    // R6: sticky slow flag
    limitVal = 16'd1000;
    restartMeas();
    pulses(1200, 2);
    checkFlag("R6 set over limit", 1);
    statusRead();
    checkFlag("R6 read while present", 1);
    restartMeas();
    pulses(500, 2);
    checkFlag("R6 sticky below limit", 1);
    statusRead();
    checkFlag("R6 cleared by read", 0);

    // R7: PWM off blocks flag and counting
    @(negedge clk); pwmActive = 1'b0; limitVal = 16'd100;
    waitCycles(70000);
    checkFlag("R7 no flag while off", 0);
    readWord("R7 no stall while off", 500);
    @(negedge clk); pwmActive = 1'b1;
    waitCycles(2);
    checkFlag("R6 set after pwm on", 1);

    // R5: stall saturates
    limitVal = 16'hFFFF;
    restartMeas();
    pulses(300, 2);
    readWord("R2 period 300 again", 300);
    waitCycles(66000);
    readWord("R5 stall", 'hFFFF);

    waitCycles(5);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule